// File: doc/BRIEF.md
# Processor Power-State Sequencer

This block follows the low-power condition of a processor core from its sideband control pins. It holds one of eight state codes: Normal, Auto Halt, Stop Grant, Quick Start, Snoop, Sleep, Deep Sleep, and a transient Bus Init code. A stop-clock request parks the core in Stop Grant, or in the lighter-weight Quick Start variant when a strap captured during core reset asks for it. Sleep, Deep Sleep and Snoop are reached from those parked states. Bus Init is held while a bus initialisation runs in Stop Grant.

While the core is parked in Stop Grant or halted, asynchronous events (flush, SMI, INIT, INTR, NMI) are recorded as pending, one bit per type. When the core is back in Normal, the block issues one strobe per pending type on successive cycles, in a fixed priority order. All pins are plain level controls. No data flows through the block, so there is no valid/ready handshake.

Top module: `pwr_state_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `state_o` is 0 (Normal), and both `pend_o` and `svc_o` are 0. State codes are: 0 Normal, 1 Auto Halt, 2 Stop Grant, 3 Quick Start, 4 Snoop, 5 Sleep, 6 Deep Sleep, 7 Bus Init.
- R2: `qs_strap` is captured on every clock edge where `core_rst` is high. From Normal or Auto Halt, a high `stop_req` moves the state on the next edge. It goes to Quick Start (3) if the captured strap is 1, and to Stop Grant (2) otherwise.
- R3: In Stop Grant or Auto Halt, a high bit of `evt_i` sets the matching bit of `pend_o` on the next edge. The bit positions are: 0 flush, 1 SMI, 2 INIT, 3 INTR, 4 NMI.
- R4: Any number of assertions of one event type while parked leaves a single pending bit, and that bit produces exactly one strobe.
- R5: On each edge that starts in Normal with pending bits, `svc_o` becomes a one-cycle one-hot strobe for the highest-priority pending type, and that pending bit clears. The priority order is NMI, SMI, INIT, flush, INTR. The first strobe appears one edge after the state becomes Normal.
- R6: In Quick Start, `evt_i` and `bus_init` have no effect on `pend_o` or on `state_o`.
- R7: A high `core_rst` clears `pend_o` and `svc_o` on the next edge. In Stop Grant or Quick Start the state does not change. In Auto Halt it returns to Normal.
- R8: In Stop Grant, a high `bus_init` enters Bus Init (7). When `bus_init` falls, the state goes to Stop Grant if `stop_req` is still high, and to Normal otherwise.
- R9: In Quick Start, a low `clk_run` enters Deep Sleep (6), and a high `clk_run` returns to Quick Start. Quick Start and Stop Grant go to Normal only when `stop_req` is low.
- R10: Sleep (5) is entered only from Stop Grant while `sleep_req` is high, and it returns to Stop Grant when `sleep_req` falls. In Normal and Auto Halt, `sleep_req` is ignored.
- R11: A high `snoop_req` in Auto Halt, Stop Grant or Quick Start enters Snoop (4). Snoop returns to the state it came from once `snoop_req` is low and `bus_quiet` is high.
- R12: In Normal, a `halt_i` pulse enters Auto Halt. In Auto Halt, any high `evt_i` bit returns the state to Normal, and the event is recorded pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req | input | 1 | Stop-clock request |
| sleep_req | input | 1 | Sleep request |
| core_rst | input | 1 | Core reset; strap capture window |
| bus_init | input | 1 | Bus initialisation in progress |
| clk_run | input | 1 | Input clock is running |
| snoop_req | input | 1 | Snoop transaction present |
| bus_quiet | input | 1 | System bus idle |
| qs_strap | input | 1 | Quick Start select strap |
| halt_i | input | 1 | Halt instruction pulse |
| evt_i | input | 5 | Event inputs (0 flush, 1 SMI, 2 INIT, 3 INTR, 4 NMI) |
| state_o | output | 3 | Current state code |
| pend_o | output | 5 | Pending events, one bit per type |
| svc_o | output | 5 | One-cycle service strobes |

## Verification
Deep Sleep is the hardest state to reach from the ports. It needs a strap value captured in an earlier core-reset window, then a stop request, then the clock-running indication dropping while the state is Quick Start. The Quick Start scenario therefore first pulses `core_rst` with the strap high. It then parks the core, drives every event and a bus-init request to show they are ignored, and toggles `clk_run` into and out of Deep Sleep. Finally it resets the core again while parked, to show that the state holds.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int NUM_EVT = 5;
  localparam int STW     = 3;

  typedef enum logic [STW-1:0] {
    ST_NORMAL = 3'd0,
    ST_HALT   = 3'd1,
    ST_STOPG  = 3'd2,
    ST_QSTART = 3'd3,
    ST_SNOOP  = 3'd4,
    ST_SLEEP  = 3'd5,
    ST_DEEP   = 3'd6,
    ST_BINIT  = 3'd7
  } pstate_e;

  localparam int EV_FLUSH = 0;
  localparam int EV_SMI   = 1;
  localparam int EV_INIT  = 2;
  localparam int EV_INTR  = 3;
  localparam int EV_NMI   = 4;
endpackage

// File: rtl/pss_svc_arb.sv
module pss_svc_arb
  import pss_pkg::*;
#(
  parameter int N = NUM_EVT
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // service order, highest first
  localparam int ORDER [NUM_EVT] = '{EV_NMI, EV_SMI, EV_INIT, EV_FLUSH, EV_INTR};

  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[ORDER[k]]) begin
        gnt[ORDER[k]] = 1'b1;
        found         = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pss_pend.sv
module pss_pend
  import pss_pkg::*;
#(
  parameter int N = NUM_EVT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cap_en,
  input  logic         svc_en,
  input  logic [N-1:0] evt_in,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] svc_q
);
  logic [N-1:0] gnt;
  logic [N-1:0] take;

  pss_svc_arb #(.N(N)) u_arb (.req(pend_q), .gnt(gnt));

  assign take = svc_en ? gnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      svc_q  <= '0;
    end else if (clr) begin
      pend_q <= '0;
      svc_q  <= '0;
    end else begin
      svc_q  <= take;
      pend_q <= (pend_q & ~take) | (cap_en ? evt_in : '0);
    end
  end

  // R5
  svc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_q));

  // R5
  svc_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q != '0) |-> (($past(pend_q) & svc_q) == svc_q));

  // R4
  svc_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q != '0) |-> ((pend_q & svc_q) == '0));
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stop_req,
  input  logic    sleep_req,
  input  logic    core_rst,
  input  logic    bus_init,
  input  logic    clk_run,
  input  logic    snoop_req,
  input  logic    bus_quiet,
  input  logic    qs_strap,
  input  logic    halt_i,
  input  logic    any_evt,
  output pstate_e state_q
);
  pstate_e state_d, ret_q, ret_d;
  logic    qs_mode_q;
  pstate_e park_st;

  assign park_st = qs_mode_q ? ST_QSTART : ST_STOPG;

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (stop_req)    state_d = park_st;
        else if (halt_i) state_d = ST_HALT;
      end
      ST_HALT: begin
        if (snoop_req) begin
          state_d = ST_SNOOP;
          ret_d   = ST_HALT;
        end else if (stop_req)           state_d = park_st;
        else if (any_evt || core_rst)    state_d = ST_NORMAL;
      end
      ST_STOPG: begin
        if (snoop_req) begin
          state_d = ST_SNOOP;
          ret_d   = ST_STOPG;
        end else if (bus_init)  state_d = ST_BINIT;
        else if (!stop_req)     state_d = ST_NORMAL;
        else if (sleep_req)     state_d = ST_SLEEP;
      end
      ST_QSTART: begin
        if (snoop_req) begin
          state_d = ST_SNOOP;
          ret_d   = ST_QSTART;
        end else if (!clk_run)  state_d = ST_DEEP;
        else if (!stop_req)     state_d = ST_NORMAL;
      end
      ST_SNOOP:  if (!snoop_req && bus_quiet) state_d = ret_q;
      ST_SLEEP:  if (!sleep_req) state_d = ST_STOPG;
      ST_DEEP:   if (clk_run) state_d = ST_QSTART;
      ST_BINIT:  if (!bus_init) state_d = stop_req ? ST_STOPG : ST_NORMAL;
      default:   state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_NORMAL;
      ret_q     <= ST_HALT;
      qs_mode_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      if (core_rst) qs_mode_q <= qs_strap;
    end
  end

  // R10
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $past(state_q) == ST_STOPG);

  // R9
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEEP && $past(state_q) != ST_DEEP) |-> $past(state_q) == ST_QSTART);

  // R11
  snoop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SNOOP && state_q != ST_SNOOP) |->
      (state_q == ST_HALT || state_q == ST_STOPG || state_q == ST_QSTART));
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic                sleep_req,
  input  logic                core_rst,
  input  logic                bus_init,
  input  logic                clk_run,
  input  logic                snoop_req,
  input  logic                bus_quiet,
  input  logic                qs_strap,
  input  logic                halt_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  output logic [STW-1:0]      state_o,
  output logic [NUM_EVT-1:0]  pend_o,
  output logic [NUM_EVT-1:0]  svc_o
);
  pstate_e st;
  logic    cap_en, svc_en;

  pss_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .sleep_req(sleep_req),
    .core_rst(core_rst), .bus_init(bus_init), .clk_run(clk_run),
    .snoop_req(snoop_req), .bus_quiet(bus_quiet), .qs_strap(qs_strap),
    .halt_i(halt_i), .any_evt(|evt_i), .state_q(st)
  );

  assign cap_en = (st == ST_STOPG) || (st == ST_HALT);
  assign svc_en = (st == ST_NORMAL);

  pss_pend #(.N(NUM_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr(core_rst), .cap_en(cap_en),
    .svc_en(svc_en), .evt_in(evt_i), .pend_q(pend_o), .svc_q(svc_o)
  );

  assign state_o = st;

  // R6
  qs_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_QSTART && !core_rst) |=> $stable(pend_o));

  // R5
  svc_only_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_o != '0) |-> $past(st) == ST_NORMAL);
endmodule

// File: tb/test_pwr_state_seq.sv
module test_pwr_state_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 0, sleep_req = 0, core_rst = 0, bus_init = 0;
  logic       clk_run = 1, snoop_req = 0, bus_quiet = 1, qs_strap = 0, halt_i = 0;
  logic [4:0] evt_i = '0;
  logic [2:0] state_o;
  logic [4:0] pend_o, svc_o;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  localparam logic [2:0] NRM = 0, AH = 1, SG = 2, QS = 3, SNP = 4, SLP = 5, DS = 6, BI = 7;

  always #2 clk = ~clk;

  pwr_state_seq i_pwr_state_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .sleep_req(sleep_req),
    .core_rst(core_rst), .bus_init(bus_init), .clk_run(clk_run),
    .snoop_req(snoop_req), .bus_quiet(bus_quiet), .qs_strap(qs_strap),
    .halt_i(halt_i), .evt_i(evt_i), .state_o(state_o), .pend_o(pend_o), .svc_o(svc_o)
  );

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    check("R1 state in reset", {5'd0, state_o}, 0);
    check("R1 pend in reset", {3'd0, pend_o}, 0);
    rst_n = 1;
    step();
    check("R1 state", {5'd0, state_o}, NRM);
    check("R1 svc", {3'd0, svc_o}, 0);
  endtask

  task automatic t_stopgrant_service;
    stop_req = 1; step();
    check("R2 stop grant", {5'd0, state_o}, SG);
    evt_i = 5'b11111; step();
    evt_i = 0; step();
    evt_i = 5'b11001; step();
    evt_i = 0;
    check("R3 pending all", {3'd0, pend_o}, 8'h1f);
    stop_req = 0; step();
    check("R9 leave to normal", {5'd0, state_o}, NRM);
    check("R5 no strobe yet", {3'd0, svc_o}, 0);
    step(); check("R5 NMI first", {3'd0, svc_o}, 8'h10);
    check("R5 NMI cleared", {3'd0, pend_o}, 8'h0f);
    step(); check("R5 SMI second", {3'd0, svc_o}, 8'h02);
    step(); check("R5 INIT third", {3'd0, svc_o}, 8'h04);
    step(); check("R5 flush fourth", {3'd0, svc_o}, 8'h01);
    step(); check("R5 INTR fifth", {3'd0, svc_o}, 8'h08);
    step(); check("R4 single strobe each", {3'd0, svc_o}, 0);
    check("R4 pending empty", {3'd0, pend_o}, 0);
  endtask

  task automatic t_quickstart;
    core_rst = 1; qs_strap = 1; step();
    core_rst = 0; qs_strap = 0;
    stop_req = 1; step();
    check("R2 quick start", {5'd0, state_o}, QS);
    evt_i = 5'b11111; bus_init = 1; step();
    evt_i = 0; bus_init = 0;
    check("R6 no latch", {3'd0, pend_o}, 0);
    check("R6 bus init ignored", {5'd0, state_o}, QS);
    clk_run = 0; step();
    check("R9 deep sleep", {5'd0, state_o}, DS);
    clk_run = 1; step();
    check("R9 back to quick start", {5'd0, state_o}, QS);
    core_rst = 1; qs_strap = 1; step();
    core_rst = 0; qs_strap = 0;
    check("R7 stays quick start", {5'd0, state_o}, QS);
    stop_req = 0; step();
    check("R9 quick start exit", {5'd0, state_o}, NRM);
    core_rst = 1; step(); core_rst = 0;
  endtask

  task automatic t_reset_parked;
    stop_req = 1; step();
    check("R2 stop grant after strap 0", {5'd0, state_o}, SG);
    evt_i = 5'b00001; step(); evt_i = 0;
    check("R3 flush pending", {3'd0, pend_o}, 8'h01);
    core_rst = 1; step(); core_rst = 0;
    check("R7 stays stop grant", {5'd0, state_o}, SG);
    check("R7 pending cleared", {3'd0, pend_o}, 0);
  endtask

  task automatic t_bus_init;
    bus_init = 1; step();
    check("R8 bus init state", {5'd0, state_o}, BI);
    bus_init = 0; step();
    check("R8 back to stop grant", {5'd0, state_o}, SG);
    bus_init = 1; step();
    bus_init = 0; stop_req = 0; step();
    check("R8 to normal", {5'd0, state_o}, NRM);
  endtask

  task automatic t_sleep;
    sleep_req = 1; step();
    check("R10 ignored in normal", {5'd0, state_o}, NRM);
    halt_i = 1; step(); halt_i = 0;
    check("R12 auto halt", {5'd0, state_o}, AH);
    step();
    check("R10 ignored in halt", {5'd0, state_o}, AH);
    stop_req = 1; step();
    check("R2 halt to stop grant", {5'd0, state_o}, SG);
    step();
    check("R10 sleep", {5'd0, state_o}, SLP);
    sleep_req = 0; step();
    check("R10 sleep exit", {5'd0, state_o}, SG);
    stop_req = 0; step();
  endtask

  task automatic t_snoop;
    halt_i = 1; step(); halt_i = 0;
    snoop_req = 1; bus_quiet = 0; step();
    check("R11 snoop from halt", {5'd0, state_o}, SNP);
    snoop_req = 0; step();
    check("R11 wait quiet", {5'd0, state_o}, SNP);
    bus_quiet = 1; step();
    check("R11 back to halt", {5'd0, state_o}, AH);
    stop_req = 1; step();
    snoop_req = 1; step(); snoop_req = 0; step();
    check("R11 back to stop grant", {5'd0, state_o}, SG);
    stop_req = 0; step();
  endtask

  task automatic t_halt_wake;
    halt_i = 1; step(); halt_i = 0;
    evt_i = 5'b01000; step(); evt_i = 0;
    check("R12 event wakes", {5'd0, state_o}, NRM);
    check("R12 INTR pending", {3'd0, pend_o}, 8'h08);
    step();
    check("R12 INTR strobe", {3'd0, svc_o}, 8'h08);
    halt_i = 1; step(); halt_i = 0;
    core_rst = 1; step(); core_rst = 0;
    check("R7 reset leaves halt", {5'd0, state_o}, NRM);
  endtask

  initial begin
    #1;
    step(2);
    t_reset();
    t_stopgrant_service();
    t_quickstart();
    t_reset_parked();
    t_bus_init();
    t_sleep();
    t_snoop();
    t_halt_wake();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule